// File: doc/BRIEF.md
# Backplane Interrupt Requester with Vector Response

This block lets a local host raise an interrupt on a shared backplane at any one of seven priority levels, then answer the backplane's acknowledge cycle for that level with an 8-bit status/ID byte. The host programs a level register and a vector register through a small write port. A write of any data to a third address, the trigger, starts the request. From then on the selected interrupt line is pulled low and stays low until this block has answered its own acknowledge cycle.

On the backplane side the block watches the incoming acknowledge daisy-chain signal, the three address lines that carry the acknowledged level, and the two data strobes. It claims the acknowledge when it has a request pending at the level on the address lines. It then presents the vector on the low data byte with an enable and asserts data acknowledge until the strobes are released. Any acknowledge it does not claim is passed on to the next board through the daisy-chain output. All bus inputs are assumed to be synchronized to `clk` already. The open-drain drivers and transceivers sit outside the block: each interrupt line is an active-low enable of a pull-down.

Top module: `irq_vector_responder`

## Requirements
- R1: After a synchronous active-low reset, and while reset is held, every bit of `bus_irq_n` is 1, `bus_dtack_n` is 1, `bus_iack_out_n` is 1, `bus_vec_oe` is 0, and no request is pending.
- R2: Host address 0 holds the request level (low 3 bits of the write data, value k selects `bus_irq_n[k-1]`) and host address 1 holds the 8-bit vector. The values in these registers when the trigger is written are the ones used for that request.
- R3: A host write of any data to address 2, with no request pending and a nonzero level, drives `bus_irq_n[level-1]` low after that clock edge. All other lines stay high.
- R4: While a request is pending, trigger writes are ignored, and writes to the level or vector registers do not change the active line or the vector returned for it.
- R5: A trigger write while the level register holds 0 raises no line and leaves no request pending.
- R6: When, at a clock edge, `bus_iack_in_n` is 0, at least one bit of `bus_ds_n` is 0, a request is pending and `bus_addr` equals its level, then from that edge `bus_dtack_n` is 0, `bus_vec_oe` is 1, `bus_vec` carries the vector and `bus_iack_out_n` stays 1.
- R7: When an acknowledge starts (`bus_iack_in_n` 0 and a strobe low) and the R6 condition fails, from that edge `bus_iack_out_n` follows `bus_iack_in_n` until `bus_iack_in_n` returns to 1. `bus_dtack_n` stays 1, and a pending request stays asserted.
- R8: Data acknowledge and the vector stay on while any strobe is low. From the first edge with both strobes high, `bus_dtack_n` is 1, `bus_vec_oe` is 0, the request is cleared and its line is released.
- R9: At most one bit of `bus_irq_n` is 0 at any time.
- R10: `bus_vec` is all zeros whenever `bus_vec_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 2 | Host register select: 0 level, 1 vector, 2 trigger |
| host_wdata | input | 8 | Host write data |
| bus_irq_n | output | 7 | Interrupt line pull-down enables, bit k-1 for level k, active low |
| bus_iack_in_n | input | 1 | Acknowledge daisy-chain input, active low |
| bus_addr | input | 3 | Acknowledged level from address lines A3..A1 |
| bus_ds_n | input | 2 | Data strobes, active low |
| bus_iack_out_n | output | 1 | Acknowledge daisy-chain output, active low |
| bus_dtack_n | output | 1 | Data acknowledge, active low |
| bus_vec_oe | output | 1 | Output enable for the vector byte drivers |
| bus_vec | output | 8 | Vector byte for D7..D0 |

## Verification
The bench builds the block with its default parameters: seven levels, an 8-bit vector and two data strobes. With these values every line from level 1 to level 7 and the out-of-range level 0 can be reached from the host port. The table walks levels across the whole range against both matching and mismatching acknowledge addresses and vectors 00 and FF. Directed tests cover re-triggering and reprogramming while a request is pending, a request on level 0, an acknowledge on the upper strobe only, and reset in the middle of a request.

// File: rtl/irqv_pkg.sv
// irqv_pkg: shared types and host register addresses for the interrupt
// requester. Assumes a 2-bit host address space.
package irqv_pkg;

    // Host register map
    localparam logic [1:0] HADDR_LEVEL   = 2'd0;
    localparam logic [1:0] HADDR_VECTOR  = 2'd1;
    localparam logic [1:0] HADDR_TRIGGER = 2'd2;

    // Acknowledge engine states
    typedef enum logic [1:0] {
        ACK_IDLE = 2'd0,
        ACK_RESP = 2'd1,
        ACK_PASS = 2'd2
    } ack_state_t;

endpackage

// File: rtl/irqv_regs.sv
// irqv_regs: host-programmed level and vector, plus the pending request.
// On an accepted trigger the programmed level and vector are copied into
// the active pair, so later host writes cannot disturb a request in flight.
// Assumes clr_req is only raised while a request is pending.
module irqv_regs
    import irqv_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [1:0]       host_addr,
    input  logic [VEC_W-1:0] host_wdata,
    input  logic             clr_req,
    output logic             pending,
    output logic [LVL_W-1:0] act_level,
    output logic [VEC_W-1:0] act_vector
);

    logic [LVL_W-1:0] prog_level;
    logic [VEC_W-1:0] prog_vector;
    logic             trig_wr;
    logic             trig_take;

    assign trig_wr   = host_wr && (host_addr == HADDR_TRIGGER);
    assign trig_take = trig_wr && !pending && (prog_level != '0);

    // Programmed level and vector registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_level  <= '0;
            prog_vector <= '0;
        end else if (host_wr) begin
            if (host_addr == HADDR_LEVEL)  prog_level  <= host_wdata[LVL_W-1:0];
            if (host_addr == HADDR_VECTOR) prog_vector <= host_wdata;
        end
    end

    // Pending flag with snapshot of the active level and vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending    <= 1'b0;
            act_level  <= '0;
            act_vector <= '0;
        end else if (clr_req) begin
            pending    <= 1'b0;
        end else if (trig_take) begin
            pending    <= 1'b1;
            act_level  <= prog_level;
            act_vector <= prog_vector;
        end
    end

    AST_RETRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && trig_wr && !clr_req) |=> (pending && $stable(act_level) && $stable(act_vector))); // R4
    AST_LEVEL0_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && trig_wr && prog_level == '0) |=> !pending); // R5
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !pending); // R8

endmodule

// File: rtl/irqv_line_drive.sv
// irqv_line_drive: decodes the active level into one pull-down enable per
// interrupt line. Bit i serves level i+1. Assumes level 0 is never active.
module irqv_line_drive #(
    parameter int NUM_LEVELS = 7,
    parameter int LVL_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pending,
    input  logic [LVL_W-1:0]      act_level,
    output logic [NUM_LEVELS-1:0] irq_n
);

    // One decoder per line
    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_line
        assign irq_n[i] = !(pending && (act_level == LVL_W'(i + 1)));
    end

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~irq_n)); // R9

endmodule

// File: rtl/irqv_ack_engine.sv
// irqv_ack_engine: tracks one backplane acknowledge cycle. It claims the
// cycle when the acknowledged level matches its pending request, otherwise
// passes the daisy chain on. Assumes all bus inputs are synchronous to clk.
module irqv_ack_engine
    import irqv_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int VEC_W = 8,
    parameter int DS_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pending,
    input  logic [LVL_W-1:0] act_level,
    input  logic [VEC_W-1:0] act_vector,
    input  logic             iack_in_n,
    input  logic [LVL_W-1:0] bus_addr,
    input  logic [DS_W-1:0]  ds_n,
    output logic             iack_out_n,
    output logic             dtack_n,
    output logic             vec_oe,
    output logic [VEC_W-1:0] vec,
    output logic             clr_req
);

    ack_state_t state, state_nx;
    logic       ds_act;
    logic       cyc_start;
    logic       lvl_hit;

    assign ds_act    = !(&ds_n);
    assign cyc_start = !iack_in_n && ds_act;
    assign lvl_hit   = pending && (bus_addr == act_level);

    // Next-state selection for the acknowledge cycle
    always_comb begin
        state_nx = state;
        case (state)
            ACK_IDLE: if (cyc_start) state_nx = lvl_hit ? ACK_RESP : ACK_PASS;
            ACK_RESP: if (!ds_act)   state_nx = ACK_IDLE;
            ACK_PASS: if (iack_in_n) state_nx = ACK_IDLE;
            default:                 state_nx = ACK_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ACK_IDLE;
        else        state <= state_nx;
    end

    // Bus-side outputs decoded from the state
    assign dtack_n    = (state != ACK_RESP);
    assign vec_oe     = (state == ACK_RESP);
    assign vec        = vec_oe ? act_vector : '0;
    assign iack_out_n = (state == ACK_PASS) ? iack_in_n : 1'b1;
    assign clr_req    = (state == ACK_RESP) && !ds_act;

    AST_RESP_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> $past(pending && !iack_in_n && bus_addr == act_level)); // R6
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dtack_n && !iack_out_n)); // R7
    AST_DTACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && ds_act) |=> !dtack_n); // R8
    AST_DTACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && !ds_act) |=> (dtack_n && !vec_oe)); // R8
    AST_VEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe |-> (vec == '0)); // R10

endmodule

// File: rtl/irq_vector_responder.sv
// irq_vector_responder: top level. Host writes program a level and vector
// and trigger a backplane interrupt; the acknowledge engine answers the
// matching acknowledge cycle with the vector and releases the line.
// Assumes bus inputs are already synchronized to clk.
module irq_vector_responder #(
    parameter int NUM_LEVELS = 7,
    parameter int VEC_W      = 8,
    parameter int DS_W       = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_wr,
    input  logic [1:0]            host_addr,
    input  logic [VEC_W-1:0]      host_wdata,
    output logic [NUM_LEVELS-1:0] bus_irq_n,
    input  logic                  bus_iack_in_n,
    input  logic [$clog2(NUM_LEVELS+1)-1:0] bus_addr,
    input  logic [DS_W-1:0]       bus_ds_n,
    output logic                  bus_iack_out_n,
    output logic                  bus_dtack_n,
    output logic                  bus_vec_oe,
    output logic [VEC_W-1:0]      bus_vec
);

    localparam int LVL_W = $clog2(NUM_LEVELS + 1);

    logic             pending;
    logic             clr_req;
    logic [LVL_W-1:0] act_level;
    logic [VEC_W-1:0] act_vector;

    irqv_regs #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .clr_req    (clr_req),
        .pending    (pending),
        .act_level  (act_level),
        .act_vector (act_vector)
    );

    irqv_line_drive #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .act_level (act_level),
        .irq_n     (bus_irq_n)
    );

    irqv_ack_engine #(.LVL_W(LVL_W), .VEC_W(VEC_W), .DS_W(DS_W)) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending),
        .act_level  (act_level),
        .act_vector (act_vector),
        .iack_in_n  (bus_iack_in_n),
        .bus_addr   (bus_addr),
        .ds_n       (bus_ds_n),
        .iack_out_n (bus_iack_out_n),
        .dtack_n    (bus_dtack_n),
        .vec_oe     (bus_vec_oe),
        .vec        (bus_vec),
        .clr_req    (clr_req)
    );

endmodule

// File: tb/irq_vector_responder_test.sv
// Bench for irq_vector_responder: table walk of level/vector/address
// vectors, then directed tests for reset and corner cases.
module irq_vector_responder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [6:0] bus_irq_n;
    logic       bus_iack_in_n = 1'b1;
    logic [2:0] bus_addr = 3'd0;
    logic [1:0] bus_ds_n = 2'b11;
    logic       bus_iack_out_n;
    logic       bus_dtack_n;
    logic       bus_vec_oe;
    logic [7:0] bus_vec;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    irq_vector_responder uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .bus_irq_n(bus_irq_n),
        .bus_iack_in_n(bus_iack_in_n), .bus_addr(bus_addr), .bus_ds_n(bus_ds_n),
        .bus_iack_out_n(bus_iack_out_n), .bus_dtack_n(bus_dtack_n),
        .bus_vec_oe(bus_vec_oe), .bus_vec(bus_vec)
    );

    // {level[14:12], vector[11:4], ack address[3:1], expect claim[0]}
    localparam logic [14:0] TBL [8] = '{
        {3'd1, 8'h11, 3'd1, 1'b1},
        {3'd7, 8'hA5, 3'd7, 1'b1},
        {3'd4, 8'h3C, 3'd4, 1'b1},
        {3'd3, 8'h00, 3'd5, 1'b0},
        {3'd2, 8'hFF, 3'd2, 1'b1},
        {3'd6, 8'h5A, 3'd1, 1'b0},
        {3'd5, 8'h80, 3'd5, 1'b1},
        {3'd7, 8'h01, 3'd6, 1'b0}
    };

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_irq(input logic [2:0] lvl);
        if (lvl == 3'd0) return 7'h7F;
        return 7'h7F & ~(7'h01 << (lvl - 3'd1));
    endfunction

    task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        step();
        host_wr = 1'b0;
    endtask

    // Full claimed acknowledge on level lvl, checking the vector
    task automatic ack_hit(input string req, input logic [2:0] lvl,
                           input logic [7:0] v, input logic [1:0] ds);
        bus_iack_in_n = 1'b0; bus_addr = lvl; bus_ds_n = ds;
        step();
        chk({req, " dtack asserted"}, {31'd0, bus_dtack_n}, 32'd0);
        chk({req, " vector"}, {23'd0, bus_vec_oe, bus_vec}, {23'd0, 1'b1, v});
        chk({req, " chain held"}, {31'd0, bus_iack_out_n}, 32'd1);
        step();
        chk("R8 dtack held while strobe low", {31'd0, bus_dtack_n}, 32'd0);
        bus_ds_n = 2'b11;
        step();
        chk("R8 dtack released", {31'd0, bus_dtack_n}, 32'd1);
        chk("R8 vector off", {31'd0, bus_vec_oe}, 32'd0);
        chk("R8 line released", {25'd0, bus_irq_n}, {25'd0, 7'h7F});
        bus_iack_in_n = 1'b1;
        step();
    endtask

    // Acknowledge that must be passed down the chain
    task automatic ack_miss(input string req, input logic [2:0] a, input logic [6:0] irq_exp);
        bus_iack_in_n = 1'b0; bus_addr = a; bus_ds_n = 2'b10;
        step();
        chk({req, " chain passed"}, {31'd0, bus_iack_out_n}, 32'd0);
        chk({req, " no dtack"}, {31'd0, bus_dtack_n}, 32'd1);
        chk("R10 vector quiet", {23'd0, bus_vec_oe, bus_vec}, 32'd0);
        chk({req, " line kept"}, {25'd0, bus_irq_n}, {25'd0, irq_exp});
        bus_ds_n = 2'b11; bus_iack_in_n = 1'b1;
        step();
        chk("R7 chain follows input high", {31'd0, bus_iack_out_n}, 32'd1);
    endtask

    initial begin
        repeat (2) step();
        // R1: state during reset
        chk("R1 lines in reset", {25'd0, bus_irq_n}, {25'd0, 7'h7F});
        chk("R1 dtack in reset", {31'd0, bus_dtack_n}, 32'd1);
        chk("R1 chain in reset", {31'd0, bus_iack_out_n}, 32'd1);
        chk("R1 vec_oe in reset", {31'd0, bus_vec_oe}, 32'd0);
        rst_n = 1'b1;
        step();

        // Table walk
        for (int i = 0; i < 8; i++) begin
            logic [2:0] lvl;
            logic [7:0] v;
            logic [2:0] a;
            lvl = TBL[i][14:12]; v = TBL[i][11:4]; a = TBL[i][3:1];
            hwrite(2'd0, {5'd0, lvl});
            hwrite(2'd1, v);
            hwrite(2'd2, 8'h00);
            chk("R3 line asserted by trigger", {25'd0, bus_irq_n}, {25'd0, exp_irq(lvl)});
            if (TBL[i][0]) begin
                ack_hit("R6 claim", a, v, 2'b10);
            end else begin
                ack_miss("R7 mismatch", a, exp_irq(lvl));
                ack_hit("R6 claim after pass", lvl, v, 2'b10);
            end
        end

        // R5: level 0 trigger raises nothing; an acknowledge is passed on
        hwrite(2'd0, 8'h00);
        hwrite(2'd2, 8'hC3);
        chk("R5 no line for level 0", {25'd0, bus_irq_n}, {25'd0, 7'h7F});
        ack_miss("R5 nothing pending", 3'd0, 7'h7F);

        // R4: retrigger and reprogramming while pending
        hwrite(2'd0, 8'h02);
        hwrite(2'd1, 8'h42);
        hwrite(2'd2, 8'h01);
        hwrite(2'd0, 8'h05);
        hwrite(2'd1, 8'h99);
        hwrite(2'd2, 8'h01);
        chk("R4 line unchanged by retrigger", {25'd0, bus_irq_n}, {25'd0, exp_irq(3'd2)});
        ack_miss("R4 new level not active", 3'd5, exp_irq(3'd2));
        ack_hit("R4 original vector", 3'd2, 8'h42, 2'b01);   // upper strobe only
        // R2: registers written earlier are used by the next trigger
        hwrite(2'd2, 8'h00);
        chk("R2 programmed level used", {25'd0, bus_irq_n}, {25'd0, exp_irq(3'd5)});
        ack_hit("R2 programmed vector", 3'd5, 8'h99, 2'b00);

        // R6: strobe low without daisy-chain input does nothing
        hwrite(2'd0, 8'h03);
        hwrite(2'd1, 8'h77);
        hwrite(2'd2, 8'h00);
        bus_iack_in_n = 1'b1; bus_addr = 3'd3; bus_ds_n = 2'b10;
        step();
        chk("R6 no claim without chain input", {31'd0, bus_dtack_n}, 32'd1);
        chk("R6 chain out idle", {31'd0, bus_iack_out_n}, 32'd1);
        bus_ds_n = 2'b11;
        step();

        // R1: reset in the middle of a request
        chk("R3 line before reset", {25'd0, bus_irq_n}, {25'd0, exp_irq(3'd3)});
        rst_n = 1'b0;
        step();
        chk("R1 reset clears request", {25'd0, bus_irq_n}, {25'd0, 7'h7F});
        rst_n = 1'b1;
        step();
        chk("R1 stays clear after reset", {25'd0, bus_irq_n}, {25'd0, 7'h7F});

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule